// File: doc/BRIEF.md
# Dual-Output Registered Command Buffer with Parity Check

This block sits between a memory controller and the DRAM devices on a registered memory module. On each rising clock edge it captures a 28-position address/command field and drives every captured bit onto two identical output copies, A and B, so that each copy can serve one half of the module's load. A static configuration input chooses which 22 of the 28 positions carry live signals. The positions that are not chosen are forced low on both copies.

Data capture is gated by a capture enable derived from chip selects. There are two primary active-low selects and two additional active-low selects. The additional pair only counts when a separate enable input is high, so tying that pair inactive leaves the standard behaviour unchanged. Without an enable the data outputs keep their value and do not toggle. The clock-enable, termination-control and primary chip-select lines are registered on every cycle without gating and are duplicated to A and B.

A parity bit from the controller is captured under the same enable as the data. One cycle later it is checked against the 22 captured bits. An active-low error flag reports a mismatch and keeps its value on cycles that follow a non-capturing edge.

Top module: `cmd_regbuf`

## Requirements
- R1: The A and B data outputs are identical in every cycle.
- R2: A capture stores `d_in & mask`. With `cfg_sel`=0 the mask covers bit positions 1–5, 7, 9–12 and 17–28. With `cfg_sel`=1 it covers 1–12, 17–20, 22 and 24–28. Position p is `d_in[p-1]`. Output positions outside the mask read 0.
- R3: When the capture enable is low, the data outputs and the captured parity bit keep their previous values.
- R4: `cke_in` and `odt_in` appear on both their A and B outputs one clock later, on every cycle, whatever the chip selects are.
- R5: `cs_n` (active low) appears unchanged on `cs_a` and `cs_b` one clock later, on every cycle.
- R6: Either bit of `cs_n` being 0 enables a capture at that edge.
- R7: Either bit of `cs_ext_n` being 0 enables a capture only when `cs_ext_en`=1. With `cs_ext_en`=0 it has no effect.
- R8: After a capture, `err_n` at the next edge becomes the XOR of the 22 captured bits and the captured parity bit (odd parity): 1 when the count of ones is odd, 0 when it is even.
- R9: At an edge that does not follow a capture, `err_n` keeps its value. From reset until the first capture has been checked, `err_n` is 1.
- R10: An active-low `rst_n` clears the data, control and select outputs to 0 at once, without waiting for a clock edge, and sets `err_n` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_sel | input | 1 | Selects which 22 positions are used |
| d_in | input | 28 | Address/command field, position p on bit p-1 |
| par_in | input | 1 | Parity bit from the controller |
| cs_n | input | 2 | Primary chip selects, active low |
| cs_ext_n | input | 2 | Additional chip selects, active low |
| cs_ext_en | input | 1 | Lets the additional selects enable capture |
| cke_in | input | 2 | Clock-enable lines |
| odt_in | input | 2 | Termination-control lines |
| q_a | output | 28 | Registered data, copy A |
| q_b | output | 28 | Registered data, copy B |
| cke_a | output | 2 | Registered clock enables, copy A |
| cke_b | output | 2 | Registered clock enables, copy B |
| odt_a | output | 2 | Registered termination controls, copy A |
| odt_b | output | 2 | Registered termination controls, copy B |
| cs_a | output | 2 | Registered primary selects, copy A |
| cs_b | output | 2 | Registered primary selects, copy B |
| err_n | output | 1 | Parity error flag, active low |

## Verification
Directed vectors first drive an all-ones field through both configurations. This shows whether each mapping selects the right 22 positions and clears the rest. Next, a primary select, an additional select with its enable low and then high, and no select at all are each tried in turn. This tells apart which select paths may open the data register and confirms that the outputs hold otherwise. Parity vectors with even and odd totals, each followed by idle cycles, separate the one-cycle-late error update from the hold on non-capturing cycles. Random fields, parity bits, configurations and mostly idle selects then exercise all of these together, and a reset issued mid-run checks the asynchronous clear.

// File: rtl/cmd_regbuf_pkg.sv
package cmd_regbuf_pkg;

  localparam int FIELD_W = 28;

  // Position p (1-based) lives on bit p-1.
  function automatic logic [FIELD_W-1:0] used_mask(input logic cfg);
    logic [FIELD_W-1:0] m;
    for (int p = 1; p <= FIELD_W; p++) begin
      if (cfg)
        m[p-1] = (p <= 12) || (p >= 17 && p <= 20) || (p == 22) || (p >= 24);
      else
        m[p-1] = (p <= 5) || (p == 7) || (p >= 9 && p <= 12) || (p >= 17);
    end
    return m;
  endfunction

  // 1 when data plus parity carry an odd count of ones.
  function automatic logic odd_total(input logic [FIELD_W-1:0] d, input logic p);
    return ^{d, p};
  endfunction

endpackage

// File: rtl/cmd_regbuf_csgate.sv
module cmd_regbuf_csgate #(
  parameter int N_PRI = 2,
  parameter int N_EXT = 2
) (
  input  logic [N_PRI-1:0] pri_n,
  input  logic [N_EXT-1:0] ext_n,
  input  logic             ext_en,
  output logic             cap_en
);
  logic pri_hit;
  logic ext_hit;

  assign pri_hit = (pri_n != {N_PRI{1'b1}});
  assign ext_hit = ext_en && (ext_n != {N_EXT{1'b1}});
  assign cap_en  = pri_hit || ext_hit;
endmodule

// File: rtl/cmd_regbuf_dreg.sv
module cmd_regbuf_dreg #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic [W-1:0] lane_mask,
  input  logic [W-1:0] d,
  input  logic         par_d,
  output logic [W-1:0] q,
  output logic         par_q
);
  for (genvar i = 0; i < W; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (cap_en) q[i] <= d[i] & lane_mask[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      par_q <= 1'b0;
    else if (cap_en) par_q <= par_d;
  end
endmodule

// File: rtl/cmd_regbuf_ctlreg.sv
module cmd_regbuf_ctlreg #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/cmd_regbuf_parchk.sv
module cmd_regbuf_parchk #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic [W-1:0] data_q,
  input  logic         par_q,
  output logic         cap_vld,
  output logic         err_n
);
  logic total_odd;

  assign total_odd = ^{data_q, par_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_vld <= 1'b0;
      err_n   <= 1'b1;
    end else begin
      cap_vld <= cap_en;
      if (cap_vld) err_n <= total_odd;
    end
  end
endmodule

// File: rtl/cmd_regbuf.sv
module cmd_regbuf
  import cmd_regbuf_pkg::*;
#(
  parameter int CTL_W = 2,
  parameter int EXT_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_sel,
  input  logic [FIELD_W-1:0] d_in,
  input  logic               par_in,
  input  logic [CTL_W-1:0]   cs_n,
  input  logic [EXT_W-1:0]   cs_ext_n,
  input  logic               cs_ext_en,
  input  logic [CTL_W-1:0]   cke_in,
  input  logic [CTL_W-1:0]   odt_in,
  output logic [FIELD_W-1:0] q_a,
  output logic [FIELD_W-1:0] q_b,
  output logic [CTL_W-1:0]   cke_a,
  output logic [CTL_W-1:0]   cke_b,
  output logic [CTL_W-1:0]   odt_a,
  output logic [CTL_W-1:0]   odt_b,
  output logic [CTL_W-1:0]   cs_a,
  output logic [CTL_W-1:0]   cs_b,
  output logic               err_n
);
  localparam int SIDE_W = 3 * CTL_W;

  logic               cap_en;
  logic               cap_vld;
  logic               par_q;
  logic [FIELD_W-1:0] lane_mask;
  logic [FIELD_W-1:0] data_q;
  logic [SIDE_W-1:0]  side_q;

  assign lane_mask = used_mask(cfg_sel);

  cmd_regbuf_csgate #(.N_PRI(CTL_W), .N_EXT(EXT_W)) u_csgate (
    .pri_n (cs_n),
    .ext_n (cs_ext_n),
    .ext_en(cs_ext_en),
    .cap_en(cap_en)
  );

  cmd_regbuf_dreg #(.W(FIELD_W)) u_dreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .lane_mask(lane_mask),
    .d        (d_in),
    .par_d    (par_in),
    .q        (data_q),
    .par_q    (par_q)
  );

  cmd_regbuf_ctlreg #(.W(SIDE_W)) u_ctlreg (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({cs_n, odt_in, cke_in}),
    .q    (side_q)
  );

  cmd_regbuf_parchk #(.W(FIELD_W)) u_parchk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_en (cap_en),
    .data_q (data_q),
    .par_q  (par_q),
    .cap_vld(cap_vld),
    .err_n  (err_n)
  );

  assign q_a   = data_q;
  assign q_b   = data_q;
  assign cke_a = side_q[CTL_W-1:0];
  assign cke_b = side_q[CTL_W-1:0];
  assign odt_a = side_q[2*CTL_W-1:CTL_W];
  assign odt_b = side_q[2*CTL_W-1:CTL_W];
  assign cs_a  = side_q[3*CTL_W-1:2*CTL_W];
  assign cs_b  = side_q[3*CTL_W-1:2*CTL_W];
endmodule

// File: rtl/cmd_regbuf_chk.sv
module cmd_regbuf_chk
  import cmd_regbuf_pkg::*;
#(
  parameter int CTL_W = 2,
  parameter int EXT_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_sel,
  input logic [FIELD_W-1:0] d_in,
  input logic [CTL_W-1:0]   cs_n,
  input logic [EXT_W-1:0]   cs_ext_n,
  input logic               cs_ext_en,
  input logic [CTL_W-1:0]   cke_in,
  input logic [CTL_W-1:0]   cke_a,
  input logic [CTL_W-1:0]   cke_b,
  input logic [CTL_W-1:0]   cs_a,
  input logic [FIELD_W-1:0] q_a,
  input logic [FIELD_W-1:0] q_b,
  input logic               cap_en,
  input logic               cap_vld,
  input logic               par_q,
  input logic               err_n
);
  // R1
  a_r1_copies_match: assert property (@(posedge clk) disable iff (!rst_n)
    q_a == q_b);

  // R2
  a_r2_unused_low: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> ((q_a & ~used_mask($past(cfg_sel))) == '0));

  // R3
  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> ($stable(q_a) && $stable(par_q)));

  // R4
  a_r4_cke_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cke_a == $past(cke_in) && cke_b == $past(cke_in)));

  // R5
  a_r5_cs_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cs_a == $past(cs_n)));

  // R6
  a_r6_primary_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != '1) |=> (q_a == ($past(d_in) & used_mask($past(cfg_sel)))));

  // R7
  a_r7_ext_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n == '1 && !cs_ext_en) |=> $stable(q_a));

  a_r7_ext_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_ext_en && cs_ext_n != '1) |=> (q_a == ($past(d_in) & used_mask($past(cfg_sel)))));

  // R8
  a_r8_err_update: assert property (@(posedge clk) disable iff (!rst_n)
    cap_vld |=> (err_n == ^{$past(q_a), $past(par_q)}));

  // R9
  a_r9_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_vld |=> $stable(err_n));
endmodule

bind cmd_regbuf cmd_regbuf_chk #(.CTL_W(CTL_W), .EXT_W(EXT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_sel  (cfg_sel),
  .d_in     (d_in),
  .cs_n     (cs_n),
  .cs_ext_n (cs_ext_n),
  .cs_ext_en(cs_ext_en),
  .cke_in   (cke_in),
  .cke_a    (cke_a),
  .cke_b    (cke_b),
  .cs_a     (cs_a),
  .q_a      (q_a),
  .q_b      (q_b),
  .cap_en   (cap_en),
  .cap_vld  (cap_vld),
  .par_q    (par_q),
  .err_n    (err_n)
);

// File: tb/cmd_regbuf_bench.sv
module cmd_regbuf_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [27:0] d_in = '0;
  logic        par_in = 1'b0;
  logic [1:0]  cs_n = 2'b11;
  logic [1:0]  cs_ext_n = 2'b11;
  logic        cs_ext_en = 1'b0;
  logic [1:0]  cke_in = '0;
  logic [1:0]  odt_in = '0;
  logic [27:0] q_a, q_b;
  logic [1:0]  cke_a, cke_b, odt_a, odt_b, cs_a, cs_b;
  logic        err_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bench-side model state
  logic [27:0] m_q;
  logic        m_par, m_vld, m_err, m_cfg;
  logic [1:0]  m_cke, m_odt, m_cs;

  cmd_regbuf u_cmd_regbuf (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .d_in(d_in), .par_in(par_in),
    .cs_n(cs_n), .cs_ext_n(cs_ext_n), .cs_ext_en(cs_ext_en),
    .cke_in(cke_in), .odt_in(odt_in), .q_a(q_a), .q_b(q_b),
    .cke_a(cke_a), .cke_b(cke_b), .odt_a(odt_a), .odt_b(odt_b),
    .cs_a(cs_a), .cs_b(cs_b), .err_n(err_n)
  );

  always #2 clk = ~clk;

  // Used positions written as explicit lists of 1-based positions.
  function automatic logic [27:0] bench_mask(input logic cfg);
    logic [27:0] m = '0;
    int list0[22] = '{1,2,3,4,5,7,9,10,11,12,17,18,19,20,21,22,23,24,25,26,27,28};
    int list1[22] = '{1,2,3,4,5,6,7,8,9,10,11,12,17,18,19,20,22,24,25,26,27,28};
    foreach (list0[k]) m[(cfg ? list1[k] : list0[k]) - 1] = 1'b1;
    return m;
  endfunction

  function automatic logic bench_odd(input logic [27:0] d, input logic p);
    int ones = p;
    for (int i = 0; i < 28; i++) ones += d[i];
    return (ones % 2) == 1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_q = '0; m_par = 0; m_vld = 0; m_err = 1; m_cfg = 0;
    m_cke = '0; m_odt = '0; m_cs = '0;
  endtask

  task automatic check_outputs(input string dtag, input string etag);
    chk(dtag, {4'h0, q_a}, {4'h0, m_q});
    chk("R1", {4'h0, q_b}, {4'h0, q_a});
    chk("R2", {4'h0, q_a & ~bench_mask(m_cfg)}, 32'h0);
    chk("R4", {28'h0, cke_a, cke_b}, {28'h0, m_cke, m_cke});
    chk("R4", {28'h0, odt_a, odt_b}, {28'h0, m_odt, m_odt});
    chk("R5", {28'h0, cs_a, cs_b}, {28'h0, m_cs, m_cs});
    chk(etag, {31'h0, err_n}, {31'h0, m_err});
  endtask

  task automatic apply(input logic cfg, input logic [27:0] d, input logic par,
                       input logic [1:0] pri, input logic [1:0] ext, input logic ext_en,
                       input logic [1:0] cke, input logic [1:0] odt);
    string dtag, etag;
    logic pri_hit, ext_hit;
    @(negedge clk);
    cfg_sel = cfg; d_in = d; par_in = par; cs_n = pri; cs_ext_n = ext;
    cs_ext_en = ext_en; cke_in = cke; odt_in = odt;
    pri_hit = (pri[0] == 0) || (pri[1] == 0);
    ext_hit = ext_en && ((ext[0] == 0) || (ext[1] == 0));
    dtag = pri_hit ? "R6" : (ext_hit ? "R7" : ((ext != 2'b11) ? "R7" : "R3"));
    etag = m_vld ? "R8" : "R9";
    @(posedge clk);
    if (m_vld) m_err = bench_odd(m_q, m_par);
    m_vld = pri_hit || ext_hit;
    if (m_vld) begin
      m_q = d & bench_mask(cfg); m_par = par; m_cfg = cfg;
    end
    m_cke = cke; m_odt = odt; m_cs = pri;
    #1;
    check_outputs(dtag, etag);
  endtask

  initial begin
    void'($urandom(32'h5eed_0017));
    model_reset();
    repeat (2) @(posedge clk);
    #1;
    check_outputs("R10", "R10");
    @(negedge clk);
    rst_n = 1'b1;

    // R2: both mappings with an all-ones field
    apply(0, '1, 1, 2'b10, 2'b11, 0, 2'b01, 2'b10);
    chk("R2", {4'h0, q_a}, 32'h0FFF_0F5F);
    apply(0, 28'h123_4567, 0, 2'b11, 2'b11, 0, 2'b10, 2'b01);   // R3 hold, R8 odd ok
    apply(1, '1, 0, 2'b01, 2'b11, 0, 2'b11, 2'b11);             // R2 cfg 1
    chk("R2", {4'h0, q_a}, 32'h0FAF_0FFF);
    apply(1, 28'h0AB_CDEF, 1, 2'b11, 2'b00, 0, 2'b00, 2'b00);   // R7 blocked, R8 even -> low
    chk("R8", {31'h0, err_n}, 32'h0);
    apply(1, 28'h0AB_CDEF, 1, 2'b11, 2'b10, 1, 2'b01, 2'b01);   // R7 opens
    apply(0, 28'h555_5555, 0, 2'b11, 2'b11, 1, 2'b10, 2'b10);   // R3 idle with ext enabled
    apply(0, 28'hAAA_AAAA, 1, 2'b11, 2'b11, 0, 2'b00, 2'b11);   // R9 hold
    apply(0, 28'h000_0000, 0, 2'b00, 2'b11, 0, 2'b11, 2'b00);   // R6 both primaries
    apply(0, 28'h000_0000, 1, 2'b11, 2'b11, 0, 2'b11, 2'b00);   // R8 even total -> low
    apply(0, 28'h000_0000, 1, 2'b11, 2'b11, 0, 2'b11, 2'b00);   // R9 hold low

    for (int n = 0; n < 3000; n++) begin
      logic [1:0] pri = ($urandom % 4 == 0) ? 2'($urandom) : 2'b11;
      logic [1:0] ext = ($urandom % 4 == 0) ? 2'($urandom) : 2'b11;
      apply(1'($urandom), 28'($urandom), 1'($urandom), pri, ext, 1'($urandom),
            2'($urandom), 2'($urandom));
    end

    // R10: asynchronous reset in the middle of a cycle
    @(negedge clk);
    #1 rst_n = 1'b0;
    model_reset();
    #0.5;
    check_outputs("R10", "R10");
    @(negedge clk);
    rst_n = 1'b1;
    apply(1, 28'h0F0_F0F0, 1, 2'b11, 2'b11, 0, 2'b01, 2'b10);
    apply(1, 28'h0F0_F0F0, 1, 2'b10, 2'b11, 0, 2'b01, 2'b10);
    apply(1, 28'h0F0_F0F0, 1, 2'b11, 2'b11, 0, 2'b01, 2'b10);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule